// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block collects up to 32 interrupt request lines and hands them to a processor as one interrupt output. Each request line is captured in a sticky status bit. A per-source enable mask qualifies the status bits to produce the pending set. The lowest-numbered pending source is offered as a vector number, so the interrupt handler can find its source with a single read.

Software controls the block through eight 32-bit registers on a simple single-cycle bus. The bus has a select, a write strobe, a byte address, write data and combinational read data. The enable mask can be replaced as a whole. It can also be changed bit by bit, without a read-modify-write, through a set alias and a clear alias. Latched requests are retired by writing ones to an acknowledge register. A two-bit master register sets whether live requests may latch and whether the output may reach the processor.

Registers are word-aligned. Address bits [4:2] select the register and bits [1:0] are ignored. The word index is: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, the following hold. Status, enable and master read as zero. The vector register reads 0xFFFFFFFF. `irq_out` is low.
- R2: While master bit 1 is set, status bit i (read at byte offset 0) is set on any rising edge at which `irq_in[i]` is high. While master bit 1 is clear, inputs do not change status.
- R3: Enable (offset 8) has three write paths. A write to offset 8 replaces the whole mask. A write to offset 16 ORs the ones of the data into the mask. A write to offset 20 clears each mask bit whose data bit is one. In every case the other bits keep their value.
- R4: A write to offset 12 clears each status bit whose data bit is one. Writing 0xFFFFFFFF clears every status bit.
- R5: If an input request and an acknowledge hit the same status bit in the same cycle, the request wins and the bit stays set.
- R6: Offset 4 reads as status AND enable.
- R7: Offset 24 reads as the index of the lowest-numbered set pending bit. When no bit is pending, it reads 0xFFFFFFFF.
- R8: Offset 28 holds a two-bit master value in data bits [1:0]. Bits [31:2] read as zero.
- R9: `irq_out` is registered. One clock after master bit 0 is set while any pending bit is one, `irq_out` is high. Otherwise it is low one clock later.
- R10: Offsets 12, 16 and 20 read as zero. Writes to offsets 0, 4 and 24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq_in | input | 32 | Interrupt request lines, one per source |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench drives a request and an acknowledge of the same bit in one cycle. A controller that let the acknowledge win would lose that event and read the bit back as zero. The bench checks the vector register as sources are retired one by one, and when nothing is pending. A wrong priority chain would report a higher source or a stale index instead of all ones. It probes the lag of `irq_out` cycle by cycle, and the case where master bit 1 is clear. A design that let unarmed inputs latch, or drove the output combinationally, would show a bit or an edge one cycle too early. The alias and read-only offsets are read back, which catches a clear alias that wipes the whole mask or a write to the status offset that sticks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC = 32;
    localparam int DW   = 32;
    localparam int AW   = 5;
    localparam int IW   = $clog2(NSRC);

    typedef enum logic [2:0] {
        RS_STATUS = 3'd0,
        RS_PEND   = 3'd1,
        RS_ENABLE = 3'd2,
        RS_ACK    = 3'd3,
        RS_SETEN  = 3'd4,
        RS_CLREN  = 3'd5,
        RS_VECTOR = 3'd6,
        RS_MASTER = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic          ld_en;
        logic          set_en;
        logic          clr_en;
        logic          ack;
        logic          ld_master;
        logic [DW-1:0] data;
    } wr_cmd_t;

    function automatic reg_sel_e word_of(input logic [AW-1:0] a);
        return reg_sel_e'(a[AW-1:2]);
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output wr_cmd_t       cmd
);
    reg_sel_e rs;

    always_comb begin
        rs            = word_of(addr);
        cmd           = '0;
        cmd.data      = wdata;
        if (sel && wr) begin
            unique case (rs)
                RS_ENABLE: cmd.ld_en     = 1'b1;
                RS_SETEN:  cmd.set_en    = 1'b1;
                RS_CLREN:  cmd.clr_en    = 1'b1;
                RS_ACK:    cmd.ack       = 1'b1;
                RS_MASTER: cmd.ld_master = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_srcbank.sv
module irqc_srcbank
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_cmd_t         cmd,
    input  logic            arm,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] enable
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    assign set_vec = arm ? req : '0;
    assign clr_vec = cmd.ack ? cmd.data[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (cmd.ld_en) begin
            enable <= cmd.data[NSRC-1:0];
        end else if (cmd.set_en) begin
            enable <= enable | cmd.data[NSRC-1:0];
        end else if (cmd.clr_en) begin
            enable <= enable & ~cmd.data[NSRC-1:0];
        end
    end

    // R4: acknowledged bits without a same-cycle request are gone
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        cmd.ack |=> ((status & $past(cmd.data[NSRC-1:0] & ~set_vec)) == '0));

    // R5: a request always survives, even against an acknowledge
    a_r5_req_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R3: set alias turns on written bits
    a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
        cmd.set_en |=> ((enable & $past(cmd.data[NSRC-1:0])) == $past(cmd.data[NSRC-1:0])));

    // R3: clear alias touches only written bits
    a_r3_clr_alias: assert property (@(posedge clk) disable iff (rst)
        cmd.clr_en |=> (enable == ($past(enable) & ~$past(cmd.data[NSRC-1:0]))));

    // R2: unarmed inputs never raise status
    a_r2_unarmed: assert property (@(posedge clk) disable iff (rst)
        !arm |=> ((status & ~$past(status)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output logic            found,
    output logic [IW-1:0]   idx
);
    logic [NSRC:0]   seen;
    logic [NSRC-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign first[g]  = pend[g] & ~seen[g];
        assign seen[g+1] = seen[g] | pend[g];
    end

    assign found = seen[NSRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    // R7: the chosen source is pending and nothing below it is
    always_comb begin
        if (found) begin
            a_r7_lowest: assert (pend[idx] && ((pend & ((NSRC'(1) << idx) - NSRC'(1))) == '0));
        end
        a_r7_single: assert ($onehot0(first));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [4:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [31:0]   irq_in,
    output logic          irq_out
);
    wr_cmd_t         cmd;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] enable;
    logic [NSRC-1:0] pending;
    logic [1:0]      master;
    logic            found;
    logic [IW-1:0]   idx;
    logic            irq_q;

    irqc_decode u_dec (
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    irqc_srcbank u_bank (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .arm    (master[1]),
        .req    (irq_in[NSRC-1:0]),
        .status (status),
        .enable (enable)
    );

    assign pending = status & enable;

    irqc_prio u_prio (
        .pend  (pending),
        .found (found),
        .idx   (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            master <= 2'b00;
            irq_q  <= 1'b0;
        end else begin
            if (cmd.ld_master) master <= cmd.data[1:0];
            irq_q <= master[0] & (|pending);
        end
    end

    assign irq_out = irq_q;

    always_comb begin
        bus_rdata = '0;
        unique case (word_of(bus_addr))
            RS_STATUS: bus_rdata = DW'(status);
            RS_PEND:   bus_rdata = DW'(pending);
            RS_ENABLE: bus_rdata = DW'(enable);
            RS_VECTOR: bus_rdata = found ? DW'(idx) : '1;
            RS_MASTER: bus_rdata = DW'(master);
            default:   bus_rdata = '0;
        endcase
    end

    // R9: output follows gated pending one clock later
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
        (master[0] && (pending != '0)) |=> irq_out);
    a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
        !master[0] |=> !irq_out);

    // R10: alias and acknowledge offsets read as zero
    a_r10_wo_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (bus_addr[4:2] inside {3'd3, 3'd4, 3'd5})) |-> (bus_rdata == '0));

    // R8: master upper bits never read as one
    a_r8_master_w: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[4:2] == 3'd7) |-> (bus_rdata[31:2] == '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        bit          is_wr;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } op_t;

    localparam int NOPS = 14;
    localparam op_t TBL [0:NOPS-1] = '{
        '{1'b1, 5'd8,  32'h0000_00F0, 4'd3},
        '{1'b0, 5'd8,  32'h0000_00F0, 4'd3},
        '{1'b1, 5'd16, 32'h0000_0003, 4'd3},
        '{1'b0, 5'd8,  32'h0000_00F3, 4'd3},
        '{1'b1, 5'd20, 32'h0000_0030, 4'd3},
        '{1'b0, 5'd8,  32'h0000_00C3, 4'd3},
        '{1'b0, 5'd16, 32'h0000_0000, 4'd10},
        '{1'b0, 5'd20, 32'h0000_0000, 4'd10},
        '{1'b0, 5'd12, 32'h0000_0000, 4'd10},
        '{1'b1, 5'd28, 32'hFFFF_FFFF, 4'd8},
        '{1'b0, 5'd28, 32'h0000_0003, 4'd8},
        '{1'b1, 5'd28, 32'h0000_0000, 4'd8},
        '{1'b0, 5'd28, 32'h0000_0000, 4'd8},
        '{1'b0, 5'd0,  32'h0000_0000, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_out;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_vector_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'd0,  32'h0, "R1 status");
        rd(5'd8,  32'h0, "R1 enable");
        rd(5'd28, 32'h0, "R1 master");
        rd(5'd24, 32'hFFFF_FFFF, "R1 vector");
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);

        // table walk: R3 enable paths, R10 zero reads, R8 master width
        for (int k = 0; k < NOPS; k++) begin
            if (TBL[k].is_wr) wr(TBL[k].addr, TBL[k].data);
            else rd(TBL[k].addr, TBL[k].data, $sformatf("R%0d table op %0d", TBL[k].req, k));
        end

        // R2: unarmed input does not latch (master still 0)
        @(negedge clk); irq_in = 32'h0000_0020;
        @(negedge clk); irq_in = 32'h0;
        rd(5'd0, 32'h0, "R2 unarmed");

        // arm and enable output; enable mask is 0xC3
        wr(5'd28, 32'h3);
        @(negedge clk); irq_in = 32'h0000_0240;
        @(negedge clk); irq_in = 32'h0;
        check("R9 lag low", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R9 rise", {31'h0, irq_out}, 32'h1);
        rd(5'd0,  32'h0000_0240, "R2 status latch");
        rd(5'd4,  32'h0000_0040, "R6 pending");
        rd(5'd24, 32'd6, "R7 vector 6");

        wr(5'd16, 32'h0000_0200);
        rd(5'd4, 32'h0000_0240, "R6 pending two");
        rd(5'd24, 32'd6, "R7 lowest of two");
        wr(5'd12, 32'h0000_0040);
        rd(5'd0, 32'h0000_0200, "R4 ack one bit");
        rd(5'd24, 32'd9, "R7 vector 9");

        // R5: request and ack on bit 9 in the same cycle
        @(negedge clk);
        irq_in = 32'h0000_0200;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd12; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; irq_in = 32'h0;
        rd(5'd0, 32'h0000_0200, "R5 request wins");

        wr(5'd12, 32'h0000_0200);
        rd(5'd0, 32'h0, "R4 ack clears");
        rd(5'd24, 32'hFFFF_FFFF, "R7 none pending");
        check("R9 fall", {31'h0, irq_out}, 32'h0);

        // R10: writes to read-only offsets ignored
        wr(5'd0, 32'hFFFF_FFFF);
        wr(5'd4, 32'hFFFF_FFFF);
        wr(5'd24, 32'hFFFF_FFFF);
        rd(5'd0, 32'h0, "R10 status write ignored");
        rd(5'd8, 32'h0000_02C3, "R10 enable untouched");

        // R9: output gated by master bit 0
        wr(5'd28, 32'h2);
        @(negedge clk); irq_in = 32'h1;
        @(negedge clk); irq_in = 32'h0;
        @(negedge clk);
        check("R9 gated off", {31'h0, irq_out}, 32'h0);
        rd(5'd24, 32'd0, "R7 vector 0");
        wr(5'd28, 32'h3);
        @(negedge clk);
        check("R9 gate on", {31'h0, irq_out}, 32'h1);

        // R3: whole write of zero disables all
        wr(5'd8, 32'h0);
        rd(5'd4, 32'h0, "R3 enable zero pending");
        @(negedge clk);
        check("R9 off after disable", {31'h0, irq_out}, 32'h0);

        // R4: all-ones ack
        @(negedge clk); irq_in = 32'h8000_0011;
        @(negedge clk); irq_in = 32'h0;
        rd(5'd0, 32'h8000_0011, "R2 multi latch");
        wr(5'd12, 32'hFFFF_FFFF);
        rd(5'd0, 32'h0, "R4 ack all");

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_bad++;
                $display("FAIL watchdog: got hang expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule